// File: doc/BRIEF.md
# CCD Line-Region Timing Sequencer

This block produces the per-pixel horizontal control strobes used while a CCD frame is read out. It keeps a pixel position within the line and a line position within the frame. From the line position it picks one of three horizontal sequences: blanking, optical-black or effective-image. From the pixel position it finds the part of the line it is in: the line-start shift, the dummy pixels, the leading optical-black pixels, the active pixels or the trailing optical-black pixels. The sequence and the part of the line together set four registered outputs: the optical-black clamp, the dummy clamp, horizontal blanking and pixel blanking.

A line starts with a configurable shift interval, during which horizontal blanking is high. Then come 28 dummy pixels, 4 leading optical-black pixels, the active pixels and 48 trailing optical-black pixels. A frame has a configurable number of blanking lines, then 10 leading optical-black lines, the effective lines and 2 trailing optical-black lines. A frame-start pulse moves the sequencer back to the first blanking line. Line geometry is fixed by parameters. One input bit says whether the horizontal clocks run during vertical blanking. That bit lets the dummy clamp fire on blanking lines.

Top module: `ccd_hseq_top`

## Requirements
- R1: While reset is high on a clock edge, the outputs after that edge are ob_clamp=0, dummy_clamp=0, hblank=0 and pix_blank=1. After reset the counters start at pixel 0 of line 0. The parameters must give at least one shift pixel and at least one blanking line.
- R2: The pixel index counts 0 to LINE_TOTAL-1 and wraps, with LINE_TOTAL = SHIFT + 28 + 4 + ACT_PIX + 48. hblank is high exactly for pixel indices below SHIFT, on every kind of line.
- R3: The line index steps by one at each pixel wrap, counts 0 to FRAME_LINES-1 and wraps to 0. The lines are ordered as follows: indices below VBLANK are blanking lines; the next 10 are optical-black lines; the next ACT_LINES are effective lines; the last 2 are optical-black lines.
- R4: On blanking lines ob_clamp stays 0 and pix_blank stays 1 for the whole line.
- R5: On blanking lines dummy_clamp is high only for dummy pixels (index SHIFT to SHIFT+27), and only while hclk_vblank_en is 1. With hclk_vblank_en at 0, dummy_clamp stays 0 on those lines.
- R6: On optical-black lines ob_clamp and dummy_clamp are both high for every pixel at or after index SHIFT, and both low during the shift interval.
- R7: On effective lines ob_clamp and dummy_clamp are both high only for the last 48 pixels of the line.
- R8: On optical-black and effective lines pix_blank equals hblank: high in the shift interval, low elsewhere.
- R9: A frame_start sampled high on a clock edge sets the position to pixel 0 of line 0 on that edge, whatever the current position.
- R10: Each output takes its value on the clock edge that follows the cycle in which the position was current. The outputs therefore lag the counters by exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | Restart pulse to pixel 0 of the first blanking line |
| hclk_vblank_en | input | 1 | Horizontal clocks run during vertical blanking; enables the dummy clamp on blanking lines |
| ob_clamp | output | 1 | Optical-black clamp strobe |
| dummy_clamp | output | 1 | Dummy clamp strobe |
| hblank | output | 1 | Horizontal blanking |
| pix_blank | output | 1 | Pixel blanking, high when no valid data is present |

## Verification
The hardest situations to reach are the sequence changes at the region borders: the last blanking line into the first optical-black line, the last effective line into the trailing optical-black lines, and the frame wrap back to blanking. A frame_start that lands in the middle of a line is also hard to reach. The stimulus runs whole frames after an aligned frame_start, so every border is crossed in order. It then fires frame_start at an odd offset, resets in mid-frame and runs on past a natural frame wrap. hclk_vblank_en is switched between frames and also during a frame, so the dummy-clamp gating is seen in both states. A per-cycle reference model checks every output on every cycle. Whole-frame strobe counts are compared against counts computed from the geometry.

// File: rtl/ccd_hseq_pkg.sv
package ccd_hseq_pkg;

  localparam int unsigned DUMMY_PIX    = 28;
  localparam int unsigned LEAD_OB_PIX  = 4;
  localparam int unsigned TRAIL_OB_PIX = 48;
  localparam int unsigned FRONT_OB_LN  = 10;
  localparam int unsigned BACK_OB_LN   = 2;

  typedef enum logic [1:0] {
    SEQ_VBLANK = 2'd0,
    SEQ_VOB    = 2'd1,
    SEQ_EFF    = 2'd2
  } seq_e;

  typedef enum logic [2:0] {
    SEG_SHIFT = 3'd0,
    SEG_DUMMY = 3'd1,
    SEG_LEAD  = 3'd2,
    SEG_ACT   = 3'd3,
    SEG_TRAIL = 3'd4
  } hseg_e;

  typedef struct packed {
    logic ob;
    logic dc;
    logic hb;
    logic pb;
  } strobes_t;

  // Part of the line that pixel index p falls into
  function automatic hseg_e pix_segment(int unsigned p, int unsigned shift,
                                        int unsigned act);
    if (p < shift)                                  return SEG_SHIFT;
    else if (p < shift + DUMMY_PIX)                 return SEG_DUMMY;
    else if (p < shift + DUMMY_PIX + LEAD_OB_PIX)   return SEG_LEAD;
    else if (p < shift + DUMMY_PIX + LEAD_OB_PIX + act) return SEG_ACT;
    else                                            return SEG_TRAIL;
  endfunction

  // Horizontal sequence used by line index l
  function automatic seq_e line_sequence(int unsigned l, int unsigned vblank,
                                         int unsigned act_lines);
    if (l < vblank)                                   return SEQ_VBLANK;
    else if (l < vblank + FRONT_OB_LN)                return SEQ_VOB;
    else if (l < vblank + FRONT_OB_LN + act_lines)    return SEQ_EFF;
    else                                              return SEQ_VOB;
  endfunction

  // Strobe values for one sequence and one part of the line
  function automatic strobes_t strobe_pick(seq_e s, hseg_e g, logic hclk_en);
    strobes_t r;
    logic in_shift;
    in_shift = (g == SEG_SHIFT);
    r.hb = in_shift;
    unique case (s)
      SEQ_VBLANK: begin
        r.ob = 1'b0;
        r.dc = hclk_en && (g == SEG_DUMMY);
        r.pb = 1'b1;
      end
      SEQ_VOB: begin
        r.ob = !in_shift;
        r.dc = !in_shift;
        r.pb = in_shift;
      end
      default: begin
        r.ob = (g == SEG_TRAIL);
        r.dc = (g == SEG_TRAIL);
        r.pb = in_shift;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ccd_pix_counter.sv
module ccd_pix_counter #(
  parameter int unsigned LINE_TOTAL = 100,
  parameter int unsigned PW = $clog2(LINE_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  output logic [PW-1:0] pix,
  output logic          line_end
);
  localparam logic [PW-1:0] LAST = PW'(LINE_TOTAL - 1);

  assign line_end = (pix == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart) pix <= '0;
    else if (line_end)  pix <= '0;
    else                pix <= pix + 1'b1;
  end
endmodule

// File: rtl/ccd_line_counter.sv
module ccd_line_counter #(
  parameter int unsigned FRAME_LINES = 21,
  parameter int unsigned LW = $clog2(FRAME_LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          advance,
  output logic [LW-1:0] line
);
  localparam logic [LW-1:0] LAST = LW'(FRAME_LINES - 1);

  always_ff @(posedge clk) begin
    if (rst || restart) line <= '0;
    else if (advance)   line <= (line == LAST) ? '0 : line + 1'b1;
  end
endmodule

// File: rtl/ccd_strobe_gen.sv
module ccd_strobe_gen
  import ccd_hseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  seq_e  seq,
  input  hseg_e hseg,
  input  logic  hclk_en,
  output logic  ob_clamp,
  output logic  dummy_clamp,
  output logic  hblank,
  output logic  pix_blank
);
  strobes_t nxt;

  always_comb nxt = strobe_pick(seq, hseg, hclk_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      ob_clamp    <= 1'b0;
      dummy_clamp <= 1'b0;
      hblank      <= 1'b0;
      pix_blank   <= 1'b1;
    end else begin
      ob_clamp    <= nxt.ob;
      dummy_clamp <= nxt.dc;
      hblank      <= nxt.hb;
      pix_blank   <= nxt.pb;
    end
  end
endmodule

// File: rtl/ccd_hseq_top.sv
module ccd_hseq_top
  import ccd_hseq_pkg::*;
#(
  parameter int unsigned SHIFT_PIX    = 4,
  parameter int unsigned ACT_PIX      = 16,
  parameter int unsigned VBLANK_LINES = 3,
  parameter int unsigned ACT_LINES    = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  input  logic hclk_vblank_en,
  output logic ob_clamp,
  output logic dummy_clamp,
  output logic hblank,
  output logic pix_blank
);
  localparam int unsigned LINE_TOTAL  = SHIFT_PIX + DUMMY_PIX + LEAD_OB_PIX + ACT_PIX + TRAIL_OB_PIX;
  localparam int unsigned FRAME_LINES = VBLANK_LINES + FRONT_OB_LN + ACT_LINES + BACK_OB_LN;
  localparam int unsigned PW = $clog2(LINE_TOTAL);
  localparam int unsigned LW = $clog2(FRAME_LINES);

  // Named internal events, also used by the checker
  logic [PW-1:0] pix_cnt;
  logic [LW-1:0] line_cnt;
  logic          line_end;
  seq_e          seq_sel;
  hseg_e         hseg;

  ccd_pix_counter #(.LINE_TOTAL(LINE_TOTAL), .PW(PW)) u_pix (
    .clk(clk), .rst(rst), .restart(frame_start),
    .pix(pix_cnt), .line_end(line_end)
  );

  ccd_line_counter #(.FRAME_LINES(FRAME_LINES), .LW(LW)) u_line (
    .clk(clk), .rst(rst), .restart(frame_start),
    .advance(line_end), .line(line_cnt)
  );

  always_comb begin
    hseg    = pix_segment(32'(pix_cnt), SHIFT_PIX, ACT_PIX);
    seq_sel = line_sequence(32'(line_cnt), VBLANK_LINES, ACT_LINES);
  end

  ccd_strobe_gen u_strobe (
    .clk(clk), .rst(rst), .seq(seq_sel), .hseg(hseg),
    .hclk_en(hclk_vblank_en),
    .ob_clamp(ob_clamp), .dummy_clamp(dummy_clamp),
    .hblank(hblank), .pix_blank(pix_blank)
  );
endmodule

// File: rtl/ccd_hseq_chk.sv
module ccd_hseq_chk
  import ccd_hseq_pkg::*;
#(
  parameter int unsigned PW = 7,
  parameter int unsigned LW = 5,
  parameter int unsigned FRAME_LINES = 21
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_start,
  input logic          hclk_vblank_en,
  input logic [PW-1:0] pix_cnt,
  input logic [LW-1:0] line_cnt,
  input logic          line_end,
  input seq_e          seq_sel,
  input hseg_e         hseg,
  input logic          ob_clamp,
  input logic          dummy_clamp,
  input logic          hblank,
  input logic          pix_blank
);
  logic  valid_q;
  seq_e  seq_d;
  hseg_e hseg_d;
  logic  cfg_d;

  always_ff @(posedge clk) begin
    valid_q <= !rst;
    seq_d   <= seq_sel;
    hseg_d  <= hseg;
    cfg_d   <= hclk_vblank_en;
  end

  // R1
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!ob_clamp && !dummy_clamp && pix_blank));

  p_pix_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (line_end && !frame_start) |=> (pix_cnt == '0));

  p_hblank_shift_r2: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> (hblank == (hseg_d == SEG_SHIFT)));

  p_line_step_r3: assert property (@(posedge clk) disable iff (rst)
    (line_end && !frame_start) |=>
      (line_cnt == (($past(line_cnt) == LW'(FRAME_LINES - 1)) ? '0 : $past(line_cnt) + 1'b1)));

  p_line_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!line_end && !frame_start) |=> $stable(line_cnt));

  p_vblank_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (valid_q && seq_d == SEQ_VBLANK) |-> (!ob_clamp && pix_blank));

  p_dummy_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (valid_q && seq_d == SEQ_VBLANK && !cfg_d) |-> !dummy_clamp);

  p_obline_clamp_r6: assert property (@(posedge clk) disable iff (rst)
    (valid_q && seq_d == SEQ_VOB) |-> (ob_clamp == (hseg_d != SEG_SHIFT)));

  p_eff_clamp_r7: assert property (@(posedge clk) disable iff (rst)
    (valid_q && seq_d == SEQ_EFF) |-> (ob_clamp == (hseg_d == SEG_TRAIL)));

  p_clamp_pair_r7: assert property (@(posedge clk) disable iff (rst)
    (valid_q && seq_d != SEQ_VBLANK) |-> (ob_clamp == dummy_clamp));

  p_pblank_r8: assert property (@(posedge clk) disable iff (rst)
    (valid_q && seq_d != SEQ_VBLANK) |-> (pix_blank == hblank));

  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (pix_cnt == '0 && line_cnt == '0));
endmodule

bind ccd_hseq_top ccd_hseq_chk #(
  .PW(PW), .LW(LW), .FRAME_LINES(FRAME_LINES)
) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start),
  .hclk_vblank_en(hclk_vblank_en),
  .pix_cnt(pix_cnt), .line_cnt(line_cnt), .line_end(line_end),
  .seq_sel(seq_sel), .hseg(hseg),
  .ob_clamp(ob_clamp), .dummy_clamp(dummy_clamp),
  .hblank(hblank), .pix_blank(pix_blank)
);

// File: tb/sim_ccd_hseq_top.sv
`timescale 1ns/1ps
module sim_ccd_hseq_top;
  localparam int SH = 4, DM = 28, LD = 4, AP = 16, TR = 48;
  localparam int VB = 3, FO = 10, AL = 6, BO = 2;
  localparam int LT = SH + DM + LD + AP + TR;
  localparam int FL = VB + FO + AL + BO;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fs  = 1'b0;
  logic cfg = 1'b0;
  logic ob_clamp, dummy_clamp, hblank, pix_blank;

  always #2.5 clk = ~clk;

  ccd_hseq_top #(.SHIFT_PIX(SH), .ACT_PIX(AP), .VBLANK_LINES(VB), .ACT_LINES(AL)) u0 (
    .clk(clk), .rst(rst), .frame_start(fs), .hclk_vblank_en(cfg),
    .ob_clamp(ob_clamp), .dummy_clamp(dummy_clamp),
    .hblank(hblank), .pix_blank(pix_blank)
  );

  int checks = 0;
  int fails  = 0;
  bit running = 0;
  bit done = 0;

  // Behavioural reference model
  int m_pix = 0, m_line = 0;
  bit after_fs = 0;
  bit e_ob = 0, e_dc = 0, e_hb = 0, e_pb = 1;
  string tag_c = "R1", tag_p = "R1", tag_h = "R1";
  bit in_shift, in_dummy, in_trail, blank_ln, eff_ln;

  always @(posedge clk) begin
    if (rst) begin
      m_pix = 0; m_line = 0; after_fs = 0;
      e_ob = 0; e_dc = 0; e_hb = 0; e_pb = 1;
      tag_c = "R1"; tag_p = "R1"; tag_h = "R1";
    end else begin
      in_shift = (m_pix < SH);
      in_dummy = (m_pix >= SH) && (m_pix < SH + DM);
      in_trail = (m_pix >= LT - TR);
      blank_ln = (m_line < VB);
      eff_ln   = (m_line >= VB + FO) && (m_line < VB + FO + AL);
      e_hb = in_shift; tag_h = "R2";
      if (blank_ln) begin
        e_ob = 0; e_dc = cfg && in_dummy; e_pb = 1;
        tag_c = in_dummy ? "R5" : "R4"; tag_p = "R4";
      end else if (eff_ln) begin
        e_ob = in_trail; e_dc = in_trail; e_pb = in_shift;
        tag_c = "R7"; tag_p = "R8";
      end else begin
        e_ob = !in_shift; e_dc = !in_shift; e_pb = in_shift;
        tag_c = "R6"; tag_p = "R8";
      end
      if (after_fs) begin tag_c = "R9"; tag_p = "R9"; tag_h = "R9"; end
      after_fs = fs;
      if (fs) begin
        m_pix = 0; m_line = 0;
      end else begin
        m_pix++;
        if (m_pix == LT) begin
          m_pix = 0; m_line++;
          if (m_line == FL) m_line = 0;
        end
      end
    end
  end

  // Per-cycle compare, one cycle behind the model position (R10)
  always @(negedge clk) begin
    if (running && !done) begin
      checks++;
      if (ob_clamp !== e_ob || dummy_clamp !== e_dc || hblank !== e_hb || pix_blank !== e_pb)
        fails++;
      if (ob_clamp !== e_ob)
        $display("FAIL %s R10 ob_clamp actual %b expected %b (line %0d)", tag_c, ob_clamp, e_ob, m_line);
      if (dummy_clamp !== e_dc)
        $display("FAIL %s R10 dummy_clamp actual %b expected %b (line %0d)", tag_c, dummy_clamp, e_dc, m_line);
      if (hblank !== e_hb)
        $display("FAIL %s hblank actual %b expected %b", tag_h, hblank, e_hb);
      if (pix_blank !== e_pb)
        $display("FAIL %s pix_blank actual %b expected %b", tag_p, pix_blank, e_pb);
    end
  end

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic count_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s count actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Aligned frame: pulse frame_start, then total each strobe over one frame
  task automatic frame_window(bit cfg_val);
    int n_ob = 0, n_dc = 0, n_hb = 0, n_pb = 0;
    cfg = cfg_val;
    fs = 1'b1;
    @(negedge clk);
    fs = 1'b0;
    for (int i = 0; i < FL * LT; i++) begin
      @(negedge clk);
      n_ob += ob_clamp; n_dc += dummy_clamp; n_hb += hblank; n_pb += pix_blank;
    end
    // R3: region order gives these totals for one frame
    count_eq("R3", "ob_clamp", n_ob, (FO + BO) * (LT - SH) + AL * TR);
    count_eq("R5", "dummy_clamp", n_dc, (FO + BO) * (LT - SH) + AL * TR + (cfg_val ? VB * DM : 0));
    count_eq("R2", "hblank", n_hb, FL * SH);
    count_eq("R8", "pix_blank", n_pb, VB * LT + (FL - VB) * SH);
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    rst = 1'b1;
    cycles(2);
    running = 1;          // R1: outputs checked while reset holds
    cycles(4);
    rst = 1'b0;
    cycles(300);
    frame_window(1'b0);   // R5 gate off
    frame_window(1'b1);   // R5 gate on
    cycles(777);
    fs = 1'b1;            // R9: restart mid-line
    @(negedge clk);
    fs = 1'b0;
    cycles(150);
    cfg = 1'b0;           // toggle inside blanking lines
    cycles(100);
    cfg = 1'b1;
    cycles(400);
    rst = 1'b1;           // R1: reset mid-frame
    cycles(3);
    rst = 1'b0;
    cycles(2 * FL * LT + 50);  // R3: natural frame wrap
    finish_run();
  end

  initial begin
    cycles(100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end
endmodule